// File: doc/BRIEF.md
# Command and Data Response Timeout Counter

This block guards a card transaction against a card that never answers. It holds two down-counters. The command counter is loaded when a command goes out and is cleared when the response arrives. The data counter is loaded when a data phase opens and is cleared when a data block arrives or the transfer ends. Both counters advance only on a card-clock tick enable, so the limits are measured in card clocks and not in system clocks.

When a counter runs out, the block raises a one-cycle event toward the status logic. The command event belongs in status bit 7 and the data event in status bit 5. The command limit is 8 bits wide. The data limit is 16 bits wide. A scale input, captured at data start, lets each data count stand for 1024 card clocks, so software can express data timeouts longer than 0xFFFF clocks. A limit of zero turns the matching counter off.

Top module: `tmo_unit`

## Requirements
- R1: After reset, neither timeout event is asserted, and neither is asserted until a start strobe with a nonzero limit has been taken.
- R2: After a command start with limit N (1..255), `cmd_tmo_o` goes high for exactly one cycle, in the cycle after the clock edge that samples the Nth tick counted after the start edge. A tick in the start cycle does not count.
- R3: Counters advance only in cycles where `tick_i` is high. With `tick_i` low the count holds for any number of cycles.
- R4: A command stop strobe that comes before expiry ends the command count, and `cmd_tmo_o` stays low afterwards.
- R5: With the scale input low at data start, `dat_tmo_o` pulses for one cycle after the Nth counted tick, where N is the 16-bit data limit.
- R6: With the scale input high at data start, each data count takes 1024 ticks, so `dat_tmo_o` pulses after N*1024 ticks and not before. The tick prescaler restarts at every data start.
- R7: A limit of zero at start disables that counter, and no timeout event follows.
- R8: A stop strobe in the same cycle as the expiring tick suppresses the event. Stop strobes with no count running have no effect.
- R9: A start strobe while a count is running reloads the counter from the current limit, and expiry is timed from the new start.
- R10: A data stop strobe (block arrival or end of transfer) ends the data count, and `dat_tmo_o` stays low afterwards.
- R11: Every timeout event lasts exactly one cycle. A counter that has expired stays silent until it is started again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Card-clock tick enable |
| cmd_start_i | input | 1 | Command issued; load the command counter |
| cmd_stop_i | input | 1 | Response arrived; end the command count |
| cmd_limit_i | input | 8 | Command limit in ticks, 0 = off |
| dat_start_i | input | 1 | Data phase opened; load the data counter |
| dat_stop_i | input | 1 | Block arrived or transfer ended; end the data count |
| dat_limit_i | input | 16 | Data limit in ticks or in 1024-tick units, 0 = off |
| dat_scale_i | input | 1 | Sampled at data start: 1 = each count is 1024 ticks |
| cmd_tmo_o | output | 1 | One-cycle command timeout event (status bit 7) |
| dat_tmo_o | output | 1 | One-cycle data timeout event (status bit 5) |

## Verification
The bench counts edges exactly. It checks that each event lands on the edge of the Nth tick. A counter that is off by one, or that counts the tick in the start cycle, would fire one cycle early or late. In the scaled mode it checks that nothing fires before 2048 ticks for a limit of 2. A prescaler that is not cleared at start, or that wraps at the wrong count, would fire early. It also drives a stop into the very cycle of the expiring tick, which a design that gives expiry priority would report. Restart, zero limits and stalled ticks are covered so that a design which ignores reload, treats zero as 256 or 65536, or counts system clocks would produce an event the bench does not expect.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
  localparam int unsigned CMD_LIMIT_W = 8;
  localparam int unsigned DAT_LIMIT_W = 16;
  localparam int unsigned SCALE_LOG2  = 10;
endpackage

// File: rtl/tmo_prescaler.sv
module tmo_prescaler #(
  parameter int unsigned WIDTH = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic tick_i,
  output logic wrap_o
);
  localparam logic [WIDTH-1:0] LAST = {WIDTH{1'b1}};

  logic [WIDTH-1:0] cnt_q;

  assign wrap_o = tick_i && !clear_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  // R6
  clear_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !wrap_o);
endmodule

// File: rtl/tmo_counter.sv
module tmo_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] limit_i,
  output logic             expire_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] cnt_q;
  logic             armed_q;
  logic             exp_q;
  logic             last_step;

  assign last_step = armed_q && step_i && (cnt_q == ONE);
  assign expire_o  = exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
      exp_q   <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (start_i) begin
        cnt_q   <= limit_i;
        armed_q <= (limit_i != '0);
      end else if (last_step) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
        exp_q   <= !stop_i;
      end else if (stop_i) begin
        armed_q <= 1'b0;
      end else if (armed_q && step_i) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R11
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q |=> !exp_q);
  // R8
  stop_silences_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> !exp_q);
  // R7
  zero_limit_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && limit_i == '0) |=> !armed_q);
  // R2
  fire_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exp_q) |-> $past(armed_q));
  // R3
  hold_without_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !step_i && !start_i && !stop_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmo_unit.sv
module tmo_unit
  import tmo_pkg::*;
#(
  parameter int unsigned CMD_W    = CMD_LIMIT_W,
  parameter int unsigned DAT_W    = DAT_LIMIT_W,
  parameter int unsigned PRE_W    = SCALE_LOG2,
  parameter bit          SCALE_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             cmd_start_i,
  input  logic             cmd_stop_i,
  input  logic [CMD_W-1:0] cmd_limit_i,
  input  logic             dat_start_i,
  input  logic             dat_stop_i,
  input  logic [DAT_W-1:0] dat_limit_i,
  input  logic             dat_scale_i,
  output logic             cmd_tmo_o,
  output logic             dat_tmo_o
);
  logic dat_step;

  tmo_counter #(.WIDTH(CMD_W)) i_cmd_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (cmd_start_i),
    .stop_i   (cmd_stop_i),
    .step_i   (tick_i),
    .limit_i  (cmd_limit_i),
    .expire_o (cmd_tmo_o)
  );

  generate
    if (SCALE_EN) begin : g_scale
      logic scale_q;
      logic pre_wrap;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          scale_q <= 1'b0;
        else if (dat_start_i) scale_q <= dat_scale_i;
      end

      tmo_prescaler #(.WIDTH(PRE_W)) i_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (dat_start_i),
        .tick_i  (tick_i),
        .wrap_o  (pre_wrap)
      );

      assign dat_step = scale_q ? pre_wrap : tick_i;
    end else begin : g_plain
      logic unused_scale;
      assign unused_scale = dat_scale_i;
      assign dat_step     = tick_i;
    end
  endgenerate

  tmo_counter #(.WIDTH(DAT_W)) i_dat_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (dat_start_i),
    .stop_i   (dat_stop_i),
    .step_i   (dat_step),
    .limit_i  (dat_limit_i),
    .expire_o (dat_tmo_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!cmd_tmo_o && !dat_tmo_o));
  // R3
  tick_gates_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_step |-> tick_i);
endmodule

// File: tb/test_tmo_unit.sv
module test_tmo_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        c_start = 1'b0, c_stop = 1'b0;
  logic [7:0]  c_lim = '0;
  logic        d_start = 1'b0, d_stop = 1'b0, d_scale = 1'b0;
  logic [15:0] d_lim = '0;
  logic        cmd_tmo, dat_tmo;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmo_unit i_tmo_unit (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .cmd_start_i(c_start), .cmd_stop_i(c_stop), .cmd_limit_i(c_lim),
    .dat_start_i(d_start), .dat_stop_i(d_stop), .dat_limit_i(d_lim),
    .dat_scale_i(d_scale), .cmd_tmo_o(cmd_tmo), .dat_tmo_o(dat_tmo)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // run n cycles, return number of pulses seen on each output
  task automatic run(input int n, output int nc, output int nd);
    nc = 0; nd = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      nc += int'(cmd_tmo);
      nd += int'(dat_tmo);
    end
  endtask

  task automatic cmd_go(input logic [7:0] lim);
    c_lim = lim; c_start = 1'b1; cyc(); c_start = 1'b0;
  endtask

  task automatic dat_go(input logic [15:0] lim, input logic sc);
    d_lim = lim; d_scale = sc; d_start = 1'b1; cyc(); d_start = 1'b0;
  endtask

  task automatic t_reset();
    int nc, nd;
    check("R1 cmd after reset", int'(cmd_tmo), 0);
    check("R1 dat after reset", int'(dat_tmo), 0);
    tick = 1'b1;
    run(20, nc, nd);
    check("R1 no events without start", nc + nd, 0);
  endtask

  task automatic t_cmd_basic();
    int nc, nd;
    tick = 1'b1;
    cmd_go(8'd5);
    run(4, nc, nd);
    check("R2 no early cmd event", nc, 0);
    cyc();
    check("R2 cmd event on 5th tick", int'(cmd_tmo), 1);
    cyc();
    check("R11 cmd event one cycle", int'(cmd_tmo), 0);
    run(300, nc, nd);
    check("R11 no second cmd event", nc, 0);
  endtask

  task automatic t_tick_gate();
    int nc, nd;
    tick = 1'b0;
    cmd_go(8'd3);
    run(50, nc, nd);
    check("R3 no event without ticks", nc, 0);
    tick = 1'b1;
    run(2, nc, nd);
    check("R3 two ticks not enough", nc, 0);
    cyc();
    check("R3 event on 3rd tick", int'(cmd_tmo), 1);
    cyc();
  endtask

  task automatic t_cmd_stop();
    int nc, nd;
    tick = 1'b1;
    cmd_go(8'd6);
    run(3, nc, nd);
    c_stop = 1'b1; cyc(); c_stop = 1'b0;
    run(40, nc, nd);
    check("R4 cmd stop before expiry", nc + int'(cmd_tmo), 0);
  endtask

  task automatic t_dat_plain();
    int nc, nd;
    tick = 1'b1;
    dat_go(16'd7, 1'b0);
    run(6, nc, nd);
    check("R5 no early dat event", nd, 0);
    cyc();
    check("R5 dat event on 7th tick", int'(dat_tmo), 1);
    cyc();
    check("R11 dat event one cycle", int'(dat_tmo), 0);
  endtask

  task automatic t_dat_scaled();
    int nc, nd;
    tick = 1'b1;
    dat_go(16'd2, 1'b1);
    d_scale = 1'b0;
    run(2047, nc, nd);
    check("R6 no dat event before 2048 ticks", nd, 0);
    cyc();
    check("R6 dat event on 2048th tick", int'(dat_tmo), 1);
    run(20, nc, nd);
    check("R6 single scaled event", nd, 0);
  endtask

  task automatic t_zero();
    int nc, nd;
    tick = 1'b1;
    cmd_go(8'd0);
    dat_go(16'd0, 1'b0);
    run(400, nc, nd);
    check("R7 zero cmd limit off", nc, 0);
    check("R7 zero dat limit off", nd, 0);
  endtask

  task automatic t_same_cycle_stop();
    int nc, nd;
    tick = 1'b1;
    cmd_go(8'd3);
    run(2, nc, nd);
    c_stop = 1'b1; cyc(); c_stop = 1'b0;
    check("R8 stop on expiring tick", int'(cmd_tmo), 0);
    run(10, nc, nd);
    check("R8 stays silent", nc, 0);
    // stray stops with nothing running
    c_stop = 1'b1; d_stop = 1'b1; run(3, nc, nd); c_stop = 1'b0; d_stop = 1'b0;
    check("R8 idle stop no effect", nc + nd, 0);
  endtask

  task automatic t_restart();
    int nc, nd;
    tick = 1'b1;
    cmd_go(8'd4);
    run(3, nc, nd);
    cmd_go(8'd4);
    run(3, nc, nd);
    check("R9 no event at old deadline", nc, 0);
    cyc();
    check("R9 event from new start", int'(cmd_tmo), 1);
    cyc();
  endtask

  task automatic t_dat_stop();
    int nc, nd;
    tick = 1'b1;
    dat_go(16'd6, 1'b0);
    run(3, nc, nd);
    d_stop = 1'b1; cyc(); d_stop = 1'b0;
    run(40, nc, nd);
    check("R10 dat stop ends count", nd + int'(dat_tmo), 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #1;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    t_reset();
    t_cmd_basic();
    t_tick_gate();
    t_cmd_stop();
    t_dat_plain();
    t_dat_scaled();
    t_zero();
    t_same_cycle_stop();
    t_restart();
    t_dat_stop();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule